// File: doc/BRIEF.md
# Four-Entry One-Write One-Read Register File

This block stores four 32-bit words. A single write port places a word into one entry on the rising clock edge. A single read port shows the contents of the entry it selects. It is meant as local operand storage next to a small datapath, where a controller writes one entry and reads one entry in every cycle.

The read path has no clock. The selected word appears at the output as soon as the read address and the read enable settle. While the read enable is low, the block releases the output so that the bus floats. A write and a read may target the same entry in one cycle. The read then shows the old word until the edge and the new word after it, because no forwarding path exists. Reset does not clear the stored words, and an entry that has never been written holds an unknown value.

Top module: `regfile_1w1r`

## Requirements
- R1: When `wr_en` is 1 at a rising edge of `clk`, the entry whose binary index equals `wr_addr` (0 to 3) takes the value of `wr_data`.
- R2: When `wr_en` is 0 at a rising edge, no entry changes, whatever `wr_addr` and `wr_data` carry.
- R3: While `rd_en` is 1, `rd_data` equals the entry selected by `rd_addr` within the same cycle, with no clock edge needed after `rd_addr` changes.
- R4: While `rd_en` is 0, all 32 bits of `rd_data` are high impedance. This includes the time while reset is asserted.
- R5: When a write and a read select the same entry in one cycle, `rd_data` shows the previous contents before the edge and the written value after it.
- R6: A write to one entry in the same cycle as a read of a different entry leaves the read value untouched, and the write still lands.
- R7: Asserting `rst_n` low does not change any stored entry.
- R8: The four entries are independent: a write changes only the addressed entry, and every other entry keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rst_n | input | 1 | Active-low reset; does not touch stored words |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 2 | Index of the entry to write |
| wr_data | input | 32 | Word to store |
| rd_en | input | 1 | Read enable; low releases the output |
| rd_addr | input | 2 | Index of the entry to read |
| rd_data | output | 32 | Selected word, or high impedance when the read is disabled |

## Verification
Each entry is written with a different bit pattern: all zeros, all ones, alternating bits and a walking one. A mix-up in address decoding or a stuck data bit therefore shows up as a wrong word on a later read. Writes with the enable low carry patterns that differ from the stored ones, so a decoder that ignores the enable is caught. Same-entry write-and-read cycles are checked both before and after the edge, which separates a design with no forwarding from one that forwards or one that loses the write. Disabled reads, including those during reset, are checked for a fully floating output, and a reset pulse between writes and reads shows that the stored words survive.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  // Default geometry of the storage
  localparam int unsigned RF_WIDTH_DEF = 32;
  localparam int unsigned RF_DEPTH_DEF = 4;

  // Bits needed to index DEPTH entries (at least one)
  function automatic int unsigned rf_addr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // True when a request at address a selects entry idx
  function automatic logic rf_hit(input logic [31:0] a, input logic [31:0] idx);
    return a == idx;
  endfunction
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int unsigned DEPTH = regfile_pkg::RF_DEPTH_DEF,
  parameter int unsigned AW    = regfile_pkg::rf_addr_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  output logic [DEPTH-1:0] wr_strobe
);
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_strobe
    assign wr_strobe[gi] = wr_en &&
      regfile_pkg::rf_hit(32'(wr_addr), 32'(gi));
  end

  // R8
  wr_single_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_strobe));

  // R2
  wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (wr_strobe == '0));
endmodule

// File: rtl/rf_entry.sv
module rf_entry #(
  parameter int unsigned WIDTH = regfile_pkg::RF_WIDTH_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // Storage is left out of reset on purpose
  always_ff @(posedge clk) begin
    if (load) q <= d;
  end

  // R1
  entry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d)));

  // R2
  entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port #(
  parameter int unsigned WIDTH = regfile_pkg::RF_WIDTH_DEF,
  parameter int unsigned DEPTH = regfile_pkg::RF_DEPTH_DEF,
  parameter int unsigned AW    = regfile_pkg::rf_addr_bits(DEPTH)
) (
  input  logic [DEPTH-1:0][WIDTH-1:0] entries,
  input  logic [AW-1:0]               rd_addr,
  input  logic                        rd_en,
  output logic [WIDTH-1:0]            rd_word,
  output logic [WIDTH-1:0]            rd_data
);
  // Combinational select, no clock on the read side
  assign rd_word = entries[rd_addr];
  // Release the bus when the read is disabled
  assign rd_data = rd_en ? rd_word : {WIDTH{1'bz}};
endmodule

// File: rtl/regfile_1w1r.sv
module regfile_1w1r #(
  parameter int unsigned WIDTH = regfile_pkg::RF_WIDTH_DEF,
  parameter int unsigned DEPTH = regfile_pkg::RF_DEPTH_DEF,
  localparam int unsigned AW   = regfile_pkg::rf_addr_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [DEPTH-1:0]            wr_strobe;
  logic [DEPTH-1:0][WIDTH-1:0] entries;
  logic [WIDTH-1:0]            rd_word;
  logic                        same_entry;

  rf_wr_decode #(.DEPTH(DEPTH), .AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_strobe(wr_strobe)
  );

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    rf_entry #(.WIDTH(WIDTH)) u_entry (
      .clk(clk), .rst_n(rst_n), .load(wr_strobe[gi]), .d(wr_data),
      .q(entries[gi])
    );
  end

  rf_rd_port #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_rd (
    .entries(entries), .rd_addr(rd_addr), .rd_en(rd_en),
    .rd_word(rd_word), .rd_data(rd_data)
  );

  // Named event: write and read meet on one entry this cycle
  assign same_entry = wr_en && rd_en && (wr_addr == rd_addr);

  // R5
  collide_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    same_entry |=> (!$stable(rd_addr) || rd_word == $past(wr_data)));
endmodule

// File: tb/regfile_1w1r_bench.sv
`timescale 1ns/1ps
module regfile_1w1r_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         rd_en = 1'b0;
  logic [1:0]   rd_addr = '0;
  wire  [W-1:0] rd_data;

  regfile_1w1r u_regfile_1w1r (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    logic [W-1:0] val;
    bit           floats;
    string        tag;
  } item_t;

  item_t        sb_q[$];
  logic [W-1:0] model [4];
  int           checks = 0;
  int           errors = 0;
  bit           reported = 1'b0;

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Driver: one cycle of stimulus, expected read result pushed to the queue
  task automatic cyc(input bit we, input logic [1:0] wa, input logic [W-1:0] wd,
                     input bit re, input logic [1:0] ra, input string tag);
    item_t it;
    @(posedge clk); #1;
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra;
    it.floats = !re;
    it.val    = re ? model[ra] : '0;  // old contents before the edge
    it.tag    = tag;
    sb_q.push_back(it);
    if (we && rst_n) model[wa] = wd;
  endtask

  // Monitor: mid-cycle sample, after inputs settle and before the next edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (it.floats) begin
        if (rd_data !== {W{1'bz}}) begin
          errors++;
          $display("FAIL %s: rd_data=%h expected=%h", it.tag, rd_data, {W{1'bz}});
        end
      end else if (rd_data !== it.val) begin
        errors++;
        $display("FAIL %s: rd_data=%h expected=%h", it.tag, rd_data, it.val);
      end
    end
  end

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected end of stimulus");
    report();
  end

  initial begin
    // R4: disabled read floats while reset is held
    cyc(0, 2'd0, '0, 0, 2'd0, "R4 reset");
    cyc(0, 2'd0, '0, 0, 2'd0, "R4 reset");
    @(posedge clk); #1; rst_n = 1'b1;

    // R1, R8: distinct pattern per entry
    cyc(1, 2'd0, 32'h0000_0000, 0, 2'd0, "R4 idle");
    cyc(1, 2'd1, 32'hFFFF_FFFF, 0, 2'd0, "R4 idle");
    cyc(1, 2'd2, 32'hAAAA_5555, 0, 2'd0, "R4 idle");
    cyc(1, 2'd3, 32'h0000_0001, 0, 2'd0, "R4 idle");
    for (int i = 0; i < 4; i++) cyc(0, 2'd0, '0, 1, 2'(i), "R1 R8 readback");

    // R3: address changes every cycle, value follows without extra edge
    cyc(0, 2'd0, '0, 1, 2'd3, "R3");
    cyc(0, 2'd0, '0, 1, 2'd1, "R3");
    cyc(0, 2'd0, '0, 1, 2'd2, "R3");

    // R2: disabled writes with differing data
    cyc(0, 2'd1, 32'h1234_5678, 0, 2'd0, "R4 idle");
    cyc(0, 2'd2, 32'h0F0F_0F0F, 1, 2'd1, "R2");
    cyc(0, 2'd0, '0, 1, 2'd2, "R2");

    // R5: same entry written and read
    cyc(1, 2'd2, 32'hDEAD_BEEF, 1, 2'd2, "R5 before edge");
    cyc(0, 2'd0, '0, 1, 2'd2, "R5 after edge");
    cyc(1, 2'd0, 32'h8000_0000, 1, 2'd0, "R5 before edge");
    cyc(0, 2'd0, '0, 1, 2'd0, "R5 after edge");

    // R6: write one entry, read another
    cyc(1, 2'd3, 32'hCAFE_F00D, 1, 2'd1, "R6 read other");
    cyc(0, 2'd0, '0, 1, 2'd3, "R6 write landed");
    for (int i = 0; i < 4; i++) cyc(0, 2'd0, '0, 1, 2'(i), "R8 neighbours");

    // R7: reset pulse keeps contents
    cyc(0, 2'd0, '0, 0, 2'd0, "R4 idle");
    @(posedge clk); #1; rst_n = 1'b0;
    cyc(0, 2'd0, '0, 0, 2'd0, "R4 reset");
    @(posedge clk); #1; rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(0, 2'd0, '0, 1, 2'(i), "R7 after reset");

    cyc(0, 2'd0, '0, 0, 2'd0, "R4 disabled");
    @(posedge clk);
    @(posedge clk);
    report();
  end
endmodule